// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block programs a byte buffer into a serial NOR flash using the flash's auto-address-increment word programming. A host pulses `start` with a 24-bit start address and a byte count. The sequencer then pulls bytes from a ready/valid source two at a time. It drives a byte-level SPI shifter through a request/acknowledge handshake, with a chip-select level that frames each command.

Programming proceeds in runs. A run opens with a write-enable frame and then a frame carrying the auto-increment opcode, the full address and the first word. Each later word of the run waits for the flash to become idle, which the block learns by polling the status register. It then sends a short frame with the opcode and two data bytes only. A word whose two bytes are both erased (0xFF) is not written. Such a word closes any open run, and the address moves past it. Every run ends with a write-disable frame. The next programmed word starts a fresh run with a full address.

Top module: `aai_prog_seq`

## Requirements
- R1: A run opens with a frame holding only 0x06, followed by a frame of six bytes: 0xAD, address bits 23:16, 15:8, 7:0, then the byte at that address, then the byte after it.
- R2: Each later word in a run is preceded by status frames {0x05, 0x00}. These repeat until bit 0 of the byte returned in second position reads 0. The word then goes out as the three-byte frame {0xAD, lower-address byte, upper-address byte}.
- R3: A word whose two bytes are both 0xFF produces no program frame. The address still advances by 2, so the next run's address frame names the word after it.
- R4: A frame holding only 0x04 is sent after the last programmed word of every run. A run ends either at a blank word or at the end of the buffer.
- R5: A count of n bytes is handled as (n+1)/2 words, and exactly n bytes are taken from the source. For odd n the missing final byte is taken as 0xFF before the blank test.
- R6: `done` is high for exactly one cycle after the final frame, and no frame follows it. With a count of zero, `done` is high in the cycle after the start edge. When every word is blank, `done` follows with no frame at all.
- R7: A start with bit 0 of the address set raises `addr_err` in the next cycle. It sends no frame, takes no byte and gives no `done`.
- R8: Chip select is low for at least one cycle between any two frames, and a byte is requested only while chip select is high.
- R9: A `start` that arrives while `busy` is high has no effect on the frames sent or on `addr_err`.
- R10: After reset, chip select, `xfer_req`, `src_ready`, `busy`, `done` and `addr_err` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a programming pass |
| start_addr | input | 24 | First flash byte address (must be even) |
| byte_count | input | CNT_W | Number of bytes to program |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Block takes the source byte this cycle |
| spi_cs | output | 1 | Flash select, high during a frame |
| xfer_req | output | 1 | Byte transfer requested from the shifter |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_ack | input | 1 | Shifter finished the current byte (one-cycle pulse) |
| xfer_rx | input | 8 | Byte shifted in during that transfer |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle completion pulse |
| addr_err | output | 1 | One-cycle pulse on an odd start address |

## Verification
Two events can meet in one decision. A blank word can be found while a run is open, and that word can also be the last of the buffer. The block must then close the run with a single write disable and finish, with no extra fetch or frame. The bench provokes this with a buffer whose final word is 0xFF 0xFF after programmed data. It also uses an odd count whose padded last word turns out blank. It judges each case by comparing the captured frame list against one built from the buffer, by checking that exactly n bytes were consumed, and by requiring one `done` pulse after the last frame. A second overlap, a new `start` that lands mid-pass, is driven with an odd address, so any leak would show up as `addr_err` or as altered frames.

// File: rtl/aai_seq_pkg.sv
package aai_seq_pkg;

  localparam int ADDR_W   = 24;
  localparam int BUSY_BIT = 0;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_AAI    = 8'hAD;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] RDSR_FILL = 8'h00;
  localparam logic [7:0] BLANK     = 8'hFF;

  typedef enum logic [2:0] {
    FR_WREN, FR_FIRST, FR_NEXT, FR_RDSR, FR_WRDI
  } frame_e;

  // number of bytes in each frame kind
  function automatic logic [2:0] frame_len(frame_e k);
    case (k)
      FR_FIRST: return 3'd6;
      FR_NEXT:  return 3'd3;
      FR_RDSR:  return 3'd2;
      default:  return 3'd1;
    endcase
  endfunction

  // byte i of a frame; word is {upper byte, lower byte}
  function automatic logic [7:0] frame_byte(frame_e k, logic [2:0] i,
                                            logic [ADDR_W-1:0] a, logic [15:0] w);
    case (k)
      FR_WREN: return OP_WREN;
      FR_WRDI: return OP_WRDI;
      FR_RDSR: return (i == 3'd0) ? OP_RDSR : RDSR_FILL;
      FR_NEXT: begin
        case (i)
          3'd0:    return OP_AAI;
          3'd1:    return w[7:0];
          default: return w[15:8];
        endcase
      end
      default: begin
        case (i)
          3'd0:    return OP_AAI;
          3'd1:    return a[23:16];
          3'd2:    return a[15:8];
          3'd3:    return a[7:0];
          3'd4:    return w[7:0];
          default: return w[15:8];
        endcase
      end
    endcase
  endfunction

  function automatic logic word_blank(logic [15:0] w);
    return w == {BLANK, BLANK};
  endfunction

  function automatic int unsigned words_for(int unsigned n);
    return (n + 1) >> 1;
  endfunction

endpackage

// File: rtl/aai_word_fetch.sv
module aai_word_fetch
  import aai_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_count,
  input  logic             take,
  input  logic             src_valid,
  input  logic [7:0]       src_data,
  output logic             src_ready,
  output logic             word_valid,
  output logic [15:0]      word
);

  typedef enum logic [1:0] {W_IDLE, W_LO, W_HI, W_HAVE} wst_e;

  wst_e             st_q;
  logic [CNT_W-1:0] left_q;
  logic [7:0]       lo_q, hi_q;

  assign src_ready  = (st_q == W_LO) || (st_q == W_HI);
  assign word_valid = (st_q == W_HAVE);
  assign word       = {hi_q, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      left_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (load) begin
      left_q <= load_count;
      st_q   <= W_IDLE;
    end else begin
      case (st_q)
        W_IDLE: if (take) st_q <= W_LO;
        W_LO: if (src_valid) begin
          lo_q   <= src_data;
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            hi_q <= BLANK;
            st_q <= W_HAVE;
          end else begin
            st_q <= W_HI;
          end
        end
        W_HI: if (src_valid) begin
          hi_q   <= src_data;
          left_q <= left_q - 1'b1;
          st_q   <= W_HAVE;
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  // R5
  no_over_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (left_q != '0));

endmodule

// File: rtl/aai_frame_tx.sv
module aai_frame_tx
  import aai_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_start,
  input  frame_e            fr_kind,
  input  logic [ADDR_W-1:0] fr_addr,
  input  logic [15:0]       fr_word,
  input  logic              xfer_ack,
  input  logic [7:0]        xfer_rx,
  output logic              spi_cs,
  output logic              xfer_req,
  output logic [7:0]        xfer_tx,
  output logic              frame_done,
  output logic [7:0]        frame_rx
);

  logic              active_q, done_q;
  frame_e            kind_q;
  logic [2:0]        idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       word_q;
  logic [7:0]        rx_q;
  logic              last_byte;

  assign last_byte  = (idx_q == frame_len(kind_q) - 3'd1);
  assign spi_cs     = active_q;
  assign xfer_req   = active_q;
  assign xfer_tx    = frame_byte(kind_q, idx_q, addr_q, word_q);
  assign frame_done = done_q;
  assign frame_rx   = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      kind_q   <= FR_WREN;
      idx_q    <= '0;
      addr_q   <= '0;
      word_q   <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (fr_start) begin
        active_q <= 1'b1;
        kind_q   <= fr_kind;
        idx_q    <= '0;
        addr_q   <= fr_addr;
        word_q   <= fr_word;
      end else if (active_q && xfer_ack) begin
        rx_q <= xfer_rx;
        if (last_byte) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          idx_q <= idx_q + 3'd1;
        end
      end
    end
  end

  // R8
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr_start |-> !active_q);

endmodule

// File: rtl/aai_seq_ctrl.sv
module aai_seq_ctrl
  import aai_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              word_valid,
  input  logic [15:0]       word,
  input  logic              frame_done,
  input  logic [7:0]        frame_rx,
  input  logic              spi_cs,
  output logic              fetch_load,
  output logic              fetch_take,
  output logic              fr_start,
  output frame_e            fr_kind,
  output logic [ADDR_W-1:0] fr_addr,
  output logic [15:0]       fr_word,
  output logic              busy,
  output logic              done,
  output logic              addr_err
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_DONE} st_e;

  st_e               st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  wl_q, wl_d;
  logic              run_q, run_d;
  logic [15:0]       word_q, word_d;
  frame_e            cur_q, cur_d;
  logic              err_q, err_d;
  logic              status_busy;

  assign status_busy = frame_rx[BUSY_BIT];
  assign fetch_take  = (st_q == S_FETCH);
  assign fr_addr     = addr_q;
  assign fr_word     = word_q;
  assign busy        = (st_q != S_IDLE);
  assign done        = (st_q == S_DONE);
  assign addr_err    = err_q;

  always_comb begin
    st_d       = st_q;
    addr_d     = addr_q;
    wl_d       = wl_q;
    run_d      = run_q;
    word_d     = word_q;
    cur_d      = cur_q;
    err_d      = 1'b0;
    fr_start   = 1'b0;
    fr_kind    = FR_WREN;
    fetch_load = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        if (start_addr[0]) begin
          err_d = 1'b1;
        end else begin
          fetch_load = 1'b1;
          addr_d     = start_addr;
          wl_d       = CNT_W'(words_for(32'(byte_count)));
          run_d      = 1'b0;
          st_d       = (wl_d == '0) ? S_DONE : S_FETCH;
        end
      end
      S_FETCH: if (word_valid) begin
        word_d = word;
        if (word_blank(word)) begin
          addr_d = addr_q + ADDR_W'(2);
          wl_d   = wl_q - 1'b1;
          if (run_q) begin
            fr_start = 1'b1;
            fr_kind  = FR_WRDI;
            run_d    = 1'b0;
            st_d     = S_WAIT;
          end else begin
            st_d = (wl_q == CNT_W'(1)) ? S_DONE : S_FETCH;
          end
        end else begin
          fr_start = 1'b1;
          fr_kind  = run_q ? FR_RDSR : FR_WREN;
          st_d     = S_WAIT;
        end
      end
      S_WAIT: if (frame_done) begin
        case (cur_q)
          FR_WREN: begin
            fr_start = 1'b1;
            fr_kind  = FR_FIRST;
          end
          FR_RDSR: begin
            fr_start = 1'b1;
            fr_kind  = status_busy ? FR_RDSR : FR_NEXT;
          end
          FR_FIRST, FR_NEXT: begin
            addr_d = addr_q + ADDR_W'(2);
            wl_d   = wl_q - 1'b1;
            run_d  = 1'b1;
            if (wl_q == CNT_W'(1)) begin
              fr_start = 1'b1;
              fr_kind  = FR_WRDI;
              run_d    = 1'b0;
            end else begin
              st_d = S_FETCH;
            end
          end
          default: st_d = (wl_q == '0) ? S_DONE : S_FETCH;
        endcase
      end
      default: st_d = S_IDLE;
    endcase
    if (fr_start) cur_d = fr_kind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      wl_q   <= '0;
      run_q  <= 1'b0;
      word_q <= '0;
      cur_q  <= FR_WREN;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      wl_q   <= wl_d;
      run_q  <= run_d;
      word_q <= word_d;
      cur_q  <= cur_d;
      err_q  <= err_d;
    end
  end

  // R2
  next_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_start && fr_kind == FR_NEXT) |-> (run_q && !status_busy));

  // R3
  blank_no_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FETCH && word_valid && word_blank(word)) |-> !(fr_start && fr_kind == FR_WREN));

  // R6
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (!spi_cs && !busy));

  // R8
  launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr_start |-> !spi_cs);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !addr_err);

endmodule

// File: rtl/aai_prog_seq.sv
module aai_prog_seq
  import aai_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      start_addr,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             src_valid,
  input  logic [7:0]       src_data,
  output logic             src_ready,
  output logic             spi_cs,
  output logic             xfer_req,
  output logic [7:0]       xfer_tx,
  input  logic             xfer_ack,
  input  logic [7:0]       xfer_rx,
  output logic             busy,
  output logic             done,
  output logic             addr_err
);

  logic              fetch_load, fetch_take, word_valid;
  logic [15:0]       word;
  logic              fr_start, frame_done;
  frame_e            fr_kind;
  logic [ADDR_W-1:0] fr_addr;
  logic [15:0]       fr_word;
  logic [7:0]        frame_rx;

  aai_word_fetch #(.CNT_W(CNT_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (fetch_load),
    .load_count (byte_count),
    .take       (fetch_take),
    .src_valid  (src_valid),
    .src_data   (src_data),
    .src_ready  (src_ready),
    .word_valid (word_valid),
    .word       (word)
  );

  aai_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .byte_count (byte_count),
    .word_valid (word_valid),
    .word       (word),
    .frame_done (frame_done),
    .frame_rx   (frame_rx),
    .spi_cs     (spi_cs),
    .fetch_load (fetch_load),
    .fetch_take (fetch_take),
    .fr_start   (fr_start),
    .fr_kind    (fr_kind),
    .fr_addr    (fr_addr),
    .fr_word    (fr_word),
    .busy       (busy),
    .done       (done),
    .addr_err   (addr_err)
  );

  aai_frame_tx u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .fr_start   (fr_start),
    .fr_kind    (fr_kind),
    .fr_addr    (fr_addr),
    .fr_word    (fr_word),
    .xfer_ack   (xfer_ack),
    .xfer_rx    (xfer_rx),
    .spi_cs     (spi_cs),
    .xfer_req   (xfer_req),
    .xfer_tx    (xfer_tx),
    .frame_done (frame_done),
    .frame_rx   (frame_rx)
  );

endmodule

// File: tb/test_aai_prog_seq.sv
module test_aai_prog_seq;
  localparam int CNT_W   = 16;
  localparam int BUSY_N  = 2;
  localparam int ACK_DLY = 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [23:0]      start_addr = '0;
  logic [CNT_W-1:0] byte_count = '0;
  logic             src_valid = 1'b1;
  logic [7:0]       src_data;
  logic             src_ready, spi_cs, xfer_req, busy, done, addr_err;
  logic [7:0]       xfer_tx;
  logic             xfer_ack;
  logic [7:0]       xfer_rx;

  aai_prog_seq #(.CNT_W(CNT_W)) i_aai_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .spi_cs(spi_cs), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
    .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .busy(busy), .done(done), .addr_err(addr_err)
  );

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // byte source
  logic [7:0] mem [0:31];
  int   sidx;
  logic clr = 1'b0;
  assign src_data = mem[sidx[4:0]];
  always @(posedge clk) if (clr) sidx <= 0; else if (src_valid && src_ready) sidx <= sidx + 1;

  // frame log, sampled on the falling edge
  logic [7:0] lg [0:63][0:7];
  int   lg_len [0:63];
  int   lg_n, cur_len, poll_cnt;
  logic [7:0] cur [0:7];
  logic prev_cs = 1'b0, err_seen, done_seen;
  always @(negedge clk) begin
    if (clr) begin
      lg_n = 0; cur_len = 0; poll_cnt = 0; err_seen = 0; done_seen = 0;
    end else begin
      if (addr_err) err_seen = 1;
      if (done) done_seen = 1;
      if (xfer_ack && cur_len < 8) begin cur[cur_len] = xfer_tx; cur_len++; end
      if (prev_cs && !spi_cs) begin
        if (lg_n < 64) begin
          for (int i = 0; i < 8; i++) lg[lg_n][i] = cur[i];
          lg_len[lg_n] = cur_len;
          lg_n++;
        end
        if (cur[0] == 8'h05) poll_cnt++;
        if (cur[0] == 8'hAD) poll_cnt = 0;
        cur_len = 0;
      end
    end
    prev_cs = spi_cs;
  end

  // shifter model: status reads busy (bit 0) for BUSY_N polls after each program frame
  int dly;
  always @(posedge clk) begin
    if (!rst_n) begin
      xfer_ack <= 1'b0; dly <= 0; xfer_rx <= '0;
    end else begin
      xfer_ack <= 1'b0;
      if (xfer_req && !xfer_ack) begin
        if (dly == ACK_DLY) begin
          xfer_ack <= 1'b1;
          dly      <= 0;
          xfer_rx  <= (cur_len == 1 && cur[0] == 8'h05) ?
                      ((poll_cnt < BUSY_N) ? 8'h43 : 8'h42) : 8'h00;
        end else dly <= dly + 1;
      end
    end
  end

  // expected frames
  logic [7:0] ex [0:63][0:7];
  int   ex_len [0:63];
  int   ex_n;

  task automatic add_fr(int len, logic [7:0] b0, logic [7:0] b1 = 0, logic [7:0] b2 = 0,
                        logic [7:0] b3 = 0, logic [7:0] b4 = 0, logic [7:0] b5 = 0);
    ex_len[ex_n] = len;
    ex[ex_n][0] = b0; ex[ex_n][1] = b1; ex[ex_n][2] = b2;
    ex[ex_n][3] = b3; ex[ex_n][4] = b4; ex[ex_n][5] = b5;
    ex_n++;
  endtask

  task automatic build_exp(logic [23:0] a0, int n);
    int open = 0;
    logic [23:0] a = a0;
    ex_n = 0;
    for (int w = 0; w < (n + 1) / 2; w++) begin
      logic [7:0] lo = mem[2*w];
      logic [7:0] hi = (2*w + 1 < n) ? mem[2*w+1] : 8'hFF;
      if (lo == 8'hFF && hi == 8'hFF) begin
        if (open != 0) add_fr(1, 8'h04);
        open = 0;
      end else if (open == 0) begin
        add_fr(1, 8'h06);
        add_fr(6, 8'hAD, a[23:16], a[15:8], a[7:0], lo, hi);
        open = 1;
      end else begin
        for (int p = 0; p <= BUSY_N; p++) add_fr(2, 8'h05, 8'h00);
        add_fr(3, 8'hAD, lo, hi);
      end
      a = a + 24'd2;
    end
    if (open != 0) add_fr(1, 8'h04);
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_frames(string req);
    int bad_at = -1, ab = 0, eb = 0;
    check(lg_n == ex_n, req, "frame count", lg_n, ex_n);
    for (int f = 0; f < ex_n && f < lg_n && bad_at < 0; f++) begin
      if (lg_len[f] != ex_len[f]) begin bad_at = f; ab = lg_len[f]; eb = ex_len[f]; end
      else for (int i = 0; i < ex_len[f]; i++)
        if (bad_at < 0 && lg[f][i] != ex[f][i]) begin bad_at = f; ab = lg[f][i]; eb = ex[f][i]; end
    end
    check(bad_at < 0, req, "frame content", ab, eb);
  endtask

  task automatic clear_logs();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic pulse_start(logic [23:0] a, int n);
    @(negedge clk);
    start = 1'b1; start_addr = a; byte_count = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(string req);
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    check(done == 1'b1, req, "done seen", done, 1);
    @(negedge clk);
    check(done == 1'b0, req, "done one cycle", done, 0);
    repeat (6) @(negedge clk);
    check(spi_cs == 1'b0 && !busy, req, "quiet after done", spi_cs, 0);
  endtask

  task automatic run_case(string req, logic [23:0] a, int n);
    clear_logs();
    build_exp(a, n);
    pulse_start(a, n);
    wait_done(req);
    compare_frames(req);
    check(sidx == n, req, "bytes consumed", sidx, n);
  endtask

  task automatic set_mem(logic [7:0] d0, logic [7:0] d1, logic [7:0] d2, logic [7:0] d3,
                         logic [7:0] d4 = 8'hFF, logic [7:0] d5 = 8'hFF,
                         logic [7:0] d6 = 8'hFF, logic [7:0] d7 = 8'hFF);
    for (int i = 0; i < 32; i++) mem[i] = 8'hFF;
    mem[0] = d0; mem[1] = d1; mem[2] = d2; mem[3] = d3;
    mem[4] = d4; mem[5] = d5; mem[6] = d6; mem[7] = d7;
  endtask

  task automatic t_reset();
    check(!spi_cs && !xfer_req && !src_ready, "R10", "idle outputs", spi_cs, 0);
    check(!busy && !done && !addr_err, "R10", "idle status", busy, 0);
  endtask

  task automatic t_full_run();
    set_mem(8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66);
    run_case("R2", 24'h012340, 6);
    check(lg_len[0] == 1 && lg[0][0] == 8'h06, "R1", "enable frame", lg[0][0], 8'h06);
    check(lg[1][0] == 8'hAD && lg[1][1] == 8'h01 && lg[1][2] == 8'h23 && lg[1][3] == 8'h40
          && lg[1][4] == 8'h11 && lg[1][5] == 8'h22, "R1", "first frame", lg[1][3], 8'h40);
  endtask

  task automatic t_blank_mid();
    set_mem(8'h01, 8'h02, 8'hFF, 8'hFF, 8'h03, 8'h04, 8'h05, 8'h06);
    run_case("R3", 24'h000100, 8);
    check(lg[2][0] == 8'h04 && lg_len[2] == 1, "R4", "close at blank", lg[2][0], 8'h04);
    check(lg[4][3] == 8'h04, "R3", "readdress after blank", lg[4][3], 8'h04);
  endtask

  task automatic t_odd_counts();
    set_mem(8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h77);
    run_case("R5", 24'h000200, 5);
    set_mem(8'h10, 8'h20, 8'hFF, 8'h99);
    run_case("R5", 24'h000300, 3);
  endtask

  task automatic t_blank_last();
    set_mem(8'h01, 8'h02, 8'hFF, 8'hFF);
    run_case("R4", 24'h000010, 4);
  endtask

  task automatic t_all_blank();
    set_mem(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    run_case("R6", 24'h000400, 4);
  endtask

  task automatic t_zero();
    clear_logs();
    pulse_start(24'h000500, 0);
    check(done == 1'b1, "R6", "zero count done timing", done, 1);
    @(negedge clk);
    check(done == 1'b0 && lg_n == 0, "R6", "zero count single", done, 0);
  endtask

  task automatic t_odd_addr();
    set_mem(8'h01, 8'h02, 8'h03, 8'h04);
    clear_logs();
    pulse_start(24'h001001, 4);
    check(addr_err == 1'b1, "R7", "error pulse", addr_err, 1);
    repeat (30) @(negedge clk);
    check(lg_n == 0 && sidx == 0, "R7", "no activity", lg_n, 0);
    check(!done_seen && !busy, "R7", "no done", done_seen, 0);
  endtask

  task automatic t_busy_start();
    set_mem(8'h21, 8'h22, 8'h23, 8'h24);
    clear_logs();
    build_exp(24'h000600, 4);
    pulse_start(24'h000600, 4);
    repeat (8) @(negedge clk);
    pulse_start(24'h000701, 2);
    wait_done("R9");
    compare_frames("R9");
    check(!err_seen, "R9", "no error from ignored start", err_seen, 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_full_run();
    t_blank_mid();
    t_odd_counts();
    t_blank_last();
    t_all_blank();
    t_zero();
    t_odd_addr();
    t_busy_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule